// File: doc/BRIEF.md
# Sample Format Converter

This block conditions raw converter samples before they reach downstream processing. Each cycle it can accept one N-bit sample together with a valid strobe. It widens the sample to the next multiple of eight bits and registers the result, so the output arrives one cycle later with its own valid.

Three static control inputs set the conversion. A master enable turns conversion on. A format flag states whether the incoming code is offset binary or two's complement. A sign-extend flag asks for the upper padding bits to copy the sample sign.

Offset-binary samples are converted to two's complement by inverting the sample MSB. Sign extension is honoured only when the incoming format is two's complement. In every other case the padding bits are zero. With the enable low the sample passes through unchanged and the padding is zero.

Top module: `sample_format_conv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_sample` is all zero.
- R2: `out_valid` equals `in_valid` from the previous clock edge. The latency is exactly one cycle.
- R3: With `cfg_enable` = 0, the low N bits of `out_sample` equal the accepted `in_sample` and all padding bits are 0, whatever the other two controls are.
- R4: With `cfg_enable` = 1 and `cfg_offset_bin` = 1 (offset binary), bit N-1 of the result is the inverse of the input MSB. Bits N-2..0 are unchanged and the padding is 0, even when `cfg_sign_ext` = 1.
- R5: With `cfg_enable` = 1, `cfg_offset_bin` = 0 (two's complement) and `cfg_sign_ext` = 1, every padding bit equals the input MSB and the low N bits are unchanged.
- R6: With `cfg_enable` = 1, `cfg_offset_bin` = 0 and `cfg_sign_ext` = 0, the low N bits are unchanged and the padding is 0.
- R7: When `in_valid` is 0 at a clock edge, `out_sample` keeps its previous value.
- R8: The output width is 8*ceil(N/8), with N = `SAMPLE_W` in the range 8 to 24. This gives 16 bits for the default N = 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | SAMPLE_W | Raw sample |
| cfg_enable | input | 1 | Conversion enable |
| cfg_offset_bin | input | 1 | 1: offset binary input, 0: two's complement input |
| cfg_sign_ext | input | 1 | Sign-extend into padding (two's complement only) |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 8*ceil(SAMPLE_W/8) | Converted, byte-padded sample |

## Verification
Every result is due exactly one clock edge after the sample is presented. Only a single register lies between the input pins and the output pins. The bench drives inputs on the falling edge. It then waits one rising edge and samples the outputs on the next falling edge, halfway between edges. This is where both `out_valid` and `out_sample` are expected to have changed. The hold and valid-gap cases run the same way, with `in_valid` low, and confirm that the output did not move.

// File: rtl/sample_format_conv.sv
module sample_format_conv #(
  parameter int SAMPLE_W = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [SAMPLE_W-1:0]               in_sample,
  input  logic                              cfg_enable,
  input  logic                              cfg_offset_bin,
  input  logic                              cfg_sign_ext,
  output logic                              out_valid,
  output logic [((SAMPLE_W+7)/8)*8-1:0]     out_sample
);
  localparam int OUT_W = ((SAMPLE_W + 7) / 8) * 8;
  localparam int PAD_W = OUT_W - SAMPLE_W;
  localparam int MSB   = SAMPLE_W - 1;

  logic                flip_msb;
  logic                ext_on;
  logic [SAMPLE_W-1:0] body;
  logic [OUT_W-1:0]    wide;

  assign flip_msb = cfg_enable & cfg_offset_bin;
  assign ext_on   = cfg_enable & ~cfg_offset_bin & cfg_sign_ext;
  assign body     = {in_sample[MSB] ^ flip_msb, in_sample[MSB-1:0]};

  generate
    if (PAD_W > 0) begin : g_pad
      assign wide = {{PAD_W{ext_on & in_sample[MSB]}}, body};
    end else begin : g_nopad
      assign wide = body;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= wide;
    end
  end
endmodule

module sample_format_conv_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [SAMPLE_W-1:0]           in_sample,
  input logic                          cfg_enable,
  input logic                          cfg_offset_bin,
  input logic                          cfg_sign_ext,
  input logic                          out_valid,
  input logic [((SAMPLE_W+7)/8)*8-1:0] out_sample
);
  localparam int OUT_W = ((SAMPLE_W + 7) / 8) * 8;
  localparam int PAD_W = OUT_W - SAMPLE_W;
  localparam int MSB   = SAMPLE_W - 1;

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));
  assert_pass_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_enable) |=> out_sample[MSB:0] == $past(in_sample));
  assert_msb_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_enable && cfg_offset_bin) |=> out_sample[MSB] != $past(in_sample[MSB]));
  assert_twos_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_enable && !cfg_offset_bin) |=> out_sample[MSB:0] == $past(in_sample));

  generate
    if (PAD_W > 0) begin : g_padchk
      assert_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_enable && !cfg_offset_bin && cfg_sign_ext) |=>
          out_sample[OUT_W-1:SAMPLE_W] == {PAD_W{$past(in_sample[MSB])}});
      assert_zero_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(cfg_enable && !cfg_offset_bin && cfg_sign_ext)) |=>
          out_sample[OUT_W-1:SAMPLE_W] == '0);
    end
  endgenerate
endmodule

bind sample_format_conv sample_format_conv_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sample_format_conv_tb.sv
module sample_format_conv_tb;
  localparam int N  = 12;
  localparam int OW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [N-1:0]  in_sample = '0;
  logic          cfg_enable = 1'b0;
  logic          cfg_offset_bin = 1'b0;
  logic          cfg_sign_ext = 1'b0;
  logic          out_valid;
  logic [OW-1:0] out_sample;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sample_format_conv #(.SAMPLE_W(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_enable(cfg_enable), .cfg_offset_bin(cfg_offset_bin),
    .cfg_sign_ext(cfg_sign_ext), .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic logic [OW-1:0] model(input logic [N-1:0] s, input logic en,
                                          input logic ob, input logic se);
    logic [OW-1:0] r;
    r = {{(OW-N){1'b0}}, s};
    if (en && ob) r[N-1] = ~s[N-1];
    if (en && !ob && se && s[N-1]) r[OW-1:N] = '1;
    return r;
  endfunction

  task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [N-1:0] s, input logic en, input logic ob, input logic se);
    @(negedge clk);
    in_valid = 1'b1; in_sample = s;
    cfg_enable = en; cfg_offset_bin = ob; cfg_sign_ext = se;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [N-1:0] s, input logic en,
                         input logic ob, input logic se);
    push(s, en, ob, se);
    check(req, {15'd0, out_valid}, 16'd1);
    check(req, out_sample, model(s, en, ob, se));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b1; in_sample = 12'hFFF;
    repeat (3) @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0);
    check("R1", out_sample, 16'h0000);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0);
    check("R1", out_sample, 16'h0000);
  endtask

  task automatic t_passthru();
    run_one("R3", 12'h9A5, 1'b0, 1'b0, 1'b1);
    run_one("R3", 12'h800, 1'b0, 1'b1, 1'b1);
    run_one("R3", 12'h7FF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_offset();
    run_one("R4", 12'h800, 1'b1, 1'b1, 1'b0);
    run_one("R4", 12'h7FF, 1'b1, 1'b1, 1'b0);
    run_one("R4", 12'h123, 1'b1, 1'b1, 1'b1);
    run_one("R4", 12'hF00, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_signext();
    run_one("R5", 12'h800, 1'b1, 1'b0, 1'b1);
    run_one("R5", 12'hFFF, 1'b1, 1'b0, 1'b1);
    run_one("R5", 12'h7FF, 1'b1, 1'b0, 1'b1);
    check("R5", model(12'h801, 1'b1, 1'b0, 1'b1), 16'hF801);
  endtask

  task automatic t_zeropad();
    run_one("R6", 12'hA5A, 1'b1, 1'b0, 1'b0);
    run_one("R6", 12'h001, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    run_one("R7", 12'hC3C, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    in_sample = 12'h111; cfg_enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", out_sample, 16'hFC3C);
    check("R2", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_valid_stream();
    @(negedge clk);
    in_valid = 1'b1; in_sample = 12'h0AA;
    cfg_enable = 1'b1; cfg_offset_bin = 1'b1; cfg_sign_ext = 1'b0;
    @(negedge clk);
    check("R2", {15'd0, out_valid}, 16'd1);
    check("R4", out_sample, 16'h08AA);
    in_sample = 12'h955;
    @(negedge clk);
    check("R2", {15'd0, out_valid}, 16'd1);
    check("R4", out_sample, 16'h0155);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_width();
    check("R8", 16'($bits(out_sample)), 16'd16);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_passthru();
    t_offset();
    t_signext();
    t_zeropad();
    t_hold();
    t_valid_stream();
    t_width();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule